// File: doc/BRIEF.md
# Serial Octal Switch Latch Controller

This block is the digital control side of an eight-channel low-side switch. A host selects it by pulling chip select low, then clocks in one control bit per channel on the data-in line. Every falling edge of the serial clock shifts one bit in, with channel 8 first and channel 1 last. When chip select returns high, the received byte is copied into the output latch. The copy takes place only if the number of falling clock edges in the frame is a nonzero whole multiple of eight. Any other count leaves the latch as it was.

At the start of each frame the same shift register is loaded with eight per-channel status bits, which then leave on data-out while the control bits come in. Channels 1 and 2 also have active-low direct-drive inputs for PWM control that does not depend on the serial timing. Three reset sources are combined, and any one of them turns all eight channels off. All serial pins are synchronised into the system clock domain, so the serial clock must run well below the system clock. The pad pull-ups that make an open direct input read as high belong outside this block.

Top module: `spi_octal_latch`

## Requirements
- R1: While chip select is low, each falling edge of the serial clock shifts one data-in bit into the register. The first bit of a frame ends up in channel 8 (drv_on[7]) and the last in channel 1 (drv_on[0]).
- R2: On the rising edge of chip select, the register is copied into the latch only when the count of falling clock edges since chip select fell is a nonzero multiple of 8. A count of zero, or any count that is not a multiple of 8, leaves the latch unchanged.
- R3: Frame length has no upper limit. A 256-clock frame is accepted, and its last eight bits are latched.
- R4: Channels 1 and 2 (drv_on[0], drv_on[1]) are on when their direct input dir_n[0] or dir_n[1] is low, or when their latch bit is 1. They are off only when the direct input is high and the latch bit is 0.
- R5: Channels 3 to 8 (drv_on[7:2]) equal their latch bits, where 1 means on.
- R6: While rst is high, ext_rst_n is low or uv_rst is high, drv_on is all zero whatever the direct inputs are, and the latch is cleared to zero.
- R7: sdo_oe is low while chip select is high. It becomes high within three system clocks after chip select falls, and low again within three system clocks after it rises.
- R8: When chip select falls, the status word is loaded. sdo first shows stat_in[7], and each falling clock edge advances one position through stat_in[6] down to stat_in[0]. After eight clocks, sdo repeats the data-in bits in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ext_rst_n | input | 1 | External reset, active low |
| uv_rst | input | 1 | Undervoltage reset flag, active high |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data shifts on its falling edge |
| sdi | input | 1 | Serial data in, first bit goes to channel 8 |
| stat_in | input | 8 | Per-channel status, bit 7 is sent first |
| dir_n | input | 2 | Active-low direct drive for channels 1 and 2 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| drv_on | output | 8 | Channel on commands, bit 0 is channel 1 |

## Verification
The case that is hardest to reach is a rejected frame. Its only visible effect is that nothing changes, so the latch must first hold a value that differs from what the rejected frame would write. The bench therefore writes a known byte with a valid frame before each length under test. It then sends every length from 0 to 17, plus 24, 32 and 256, with a fresh data byte, and checks that the outputs keep or take the byte the length rule predicts. A further sweep runs all 256 latch values against all four direct-input combinations.

// File: rtl/octal_drv_pkg.sv
package octal_drv_pkg;

    localparam int CH_N        = 8;
    localparam int DIR_N       = 2;
    localparam int SYNC_STAGES = 2;
    localparam int PHASE_W     = $clog2(CH_N);

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    // a frame is accepted when it saw clocks and ended on a byte boundary
    function automatic logic frame_ok(input logic seen,
                                      input logic [PHASE_W-1:0] phase);
        return seen && (phase == '0);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import octal_drv_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n_pin,
    input  logic  sclk_pin,
    input  logic  sdi_pin,
    output edge_t cs_ev,
    output edge_t sclk_ev,
    output logic  cs_act,
    output logic  sdi_bit
);

    logic [STAGES:0] cs_q;
    logic [STAGES:0] ck_q;
    logic [STAGES:0] di_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '1;
            ck_q <= '0;
            di_q <= '0;
        end else begin
            cs_q <= {cs_q[STAGES-1:0], cs_n_pin};
            ck_q <= {ck_q[STAGES-1:0], sclk_pin};
            di_q <= {di_q[STAGES-1:0], sdi_pin};
        end
    end

    // newest settled sample is STAGES-1, one older is STAGES
    assign cs_ev.fall   = cs_q[STAGES] & ~cs_q[STAGES-1];
    assign cs_ev.rise   = ~cs_q[STAGES] & cs_q[STAGES-1];
    assign sclk_ev.fall = ck_q[STAGES] & ~ck_q[STAGES-1];
    assign sclk_ev.rise = ~ck_q[STAGES] & ck_q[STAGES-1];
    assign cs_act       = ~cs_q[STAGES];
    assign sdi_bit      = di_q[STAGES-1];

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import octal_drv_pkg::*;
#(
    parameter int W = CH_N
) (
    input  logic         clk,
    input  logic         rst,
    input  edge_t        cs_ev,
    input  edge_t        sclk_ev,
    input  logic         cs_act,
    input  logic         sdi_bit,
    input  logic [W-1:0] stat,
    output logic [W-1:0] sh,
    output logic         upd
);

    localparam int PW = $clog2(W);

    logic [PW-1:0] phase;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            phase <= '0;
            seen  <= 1'b0;
        end else if (cs_ev.fall) begin
            sh    <= stat;
            phase <= '0;
            seen  <= 1'b0;
        end else if (cs_act && sclk_ev.fall) begin
            sh    <= {sh[W-2:0], sdi_bit};
            phase <= phase + 1'b1;
            seen  <= 1'b1;
        end
    end

    assign upd = cs_ev.rise && frame_ok(seen, phase);

endmodule

// File: rtl/out_stage.sv
module out_stage
    import octal_drv_pkg::*;
#(
    parameter int W  = CH_N,
    parameter int ND = DIR_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [W-1:0]  sh,
    input  logic [ND-1:0] dir_n,
    output logic [W-1:0]  lat,
    output logic [W-1:0]  drv_on
);

    always_ff @(posedge clk) begin
        if (rst)      lat <= '0;
        else if (upd) lat <= sh;
    end

    for (genvar i = 0; i < W; i++) begin : g_ch
        if (i < ND) begin : g_direct
            assign drv_on[i] = ~rst & (lat[i] | ~dir_n[i]);
        end else begin : g_serial
            assign drv_on[i] = ~rst & lat[i];
        end
    end

endmodule

// File: rtl/spi_octal_latch.sv
module spi_octal_latch
    import octal_drv_pkg::*;
#(
    parameter int CH = CH_N,
    parameter int ND = DIR_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_rst_n,
    input  logic          uv_rst,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    input  logic [CH-1:0] stat_in,
    input  logic [ND-1:0] dir_n,
    output logic          sdo,
    output logic          sdo_oe,
    output logic [CH-1:0] drv_on
);

    logic          rst_any;
    edge_t         cs_ev;
    edge_t         sclk_ev;
    logic          cs_act;
    logic          sdi_bit;
    logic [CH-1:0] sh;
    logic          upd;
    logic [CH-1:0] lat;

    assign rst_any = rst | ~ext_rst_n | uv_rst;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst_any),
        .cs_n_pin (cs_n),
        .sclk_pin (sclk),
        .sdi_pin  (sdi),
        .cs_ev    (cs_ev),
        .sclk_ev  (sclk_ev),
        .cs_act   (cs_act),
        .sdi_bit  (sdi_bit)
    );

    frame_shifter #(.W(CH)) i_shift (
        .clk     (clk),
        .rst     (rst_any),
        .cs_ev   (cs_ev),
        .sclk_ev (sclk_ev),
        .cs_act  (cs_act),
        .sdi_bit (sdi_bit),
        .stat    (stat_in),
        .sh      (sh),
        .upd     (upd)
    );

    out_stage #(.W(CH), .ND(ND)) i_out (
        .clk    (clk),
        .rst    (rst_any),
        .upd    (upd),
        .sh     (sh),
        .dir_n  (dir_n),
        .lat    (lat),
        .drv_on (drv_on)
    );

    assign sdo    = sh[CH-1];
    assign sdo_oe = cs_act;

endmodule

// File: rtl/octal_latch_chk.sv
module octal_latch_chk
    import octal_drv_pkg::*;
#(
    parameter int W  = CH_N,
    parameter int ND = DIR_N
) (
    input logic          clk,
    input logic          rst_any,
    input edge_t         cs_ev,
    input edge_t         sclk_ev,
    input logic          cs_act,
    input logic          sdi_bit,
    input logic [W-1:0]  stat_in,
    input logic [W-1:0]  sh,
    input logic [W-1:0]  lat,
    input logic [W-1:0]  drv_on,
    input logic [ND-1:0] dir_n,
    input logic          sdo_oe
);

    a_r6_reset_off: assert property (@(posedge clk)
        rst_any |-> drv_on == '0);

    a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst_any)
        !cs_ev.rise |=> $stable(lat));

    a_r8_status_load: assert property (@(posedge clk) disable iff (rst_any)
        cs_ev.fall |=> sh == $past(stat_in));

    a_r1_shift_step: assert property (@(posedge clk) disable iff (rst_any)
        (cs_act && sclk_ev.fall && !cs_ev.fall)
        |=> sh == {$past(sh[W-2:0]), $past(sdi_bit)});

    a_r7_oe_start: assert property (@(posedge clk) disable iff (rst_any)
        $rose(sdo_oe) |-> $past(cs_ev.fall));

    a_r4_direct_ch1: assert property (@(posedge clk) disable iff (rst_any)
        !dir_n[0] |-> drv_on[0]);

    a_r4_direct_ch2: assert property (@(posedge clk) disable iff (rst_any)
        !dir_n[1] |-> drv_on[1]);

endmodule

bind spi_octal_latch octal_latch_chk #(.W(CH), .ND(ND)) i_chk (
    .clk     (clk),
    .rst_any (rst_any),
    .cs_ev   (cs_ev),
    .sclk_ev (sclk_ev),
    .cs_act  (cs_act),
    .sdi_bit (sdi_bit),
    .stat_in (stat_in),
    .sh      (sh),
    .lat     (lat),
    .drv_on  (drv_on),
    .dir_n   (dir_n),
    .sdo_oe  (sdo_oe)
);

// File: tb/test_spi_octal_latch.sv
module test_spi_octal_latch;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       uv_rst = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] stat_in = 8'h00;
    logic [1:0] dir_n = 2'b11;
    logic       sdo;
    logic       sdo_oe;
    logic [7:0] drv_on;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    spi_octal_latch i_spi_octal_latch (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .uv_rst(uv_rst),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .stat_in(stat_in),
        .dir_n(dir_n), .sdo(sdo), .sdo_oe(sdo_oe), .drv_on(drv_on)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_out(input logic [7:0] l,
                                              input logic [1:0] d);
        logic [7:0] e;
        e = l;
        if (!d[0]) e[0] = 1'b1;
        if (!d[1]) e[1] = 1'b1;
        return e;
    endfunction

    // bit sent at position j: the seed repeats MSB first every 8 clocks
    function automatic logic sent(input int j, input logic [7:0] seed);
        return seed[7 - (j % 8)];
    endfunction

    task automatic frame(input int n, input logic [7:0] seed,
                         input logic [7:0] st, input string req);
        logic [7:0] e;
        stat_in = st;
        cs_n = 1'b0;
        wt(HP);
        chk(sdo_oe === 1'b1, "R7 oe on", {31'd0, sdo_oe}, 1);
        for (int j = 0; j < n; j++) begin
            sdi  = sent(j, seed);
            sclk = 1'b1;
            wt(HP);
            e[0] = (j < 8) ? st[7 - j] : sent(j - 8, seed);
            chk(sdo === e[0], "R8 sdo bit", {31'd0, sdo}, {31'd0, e[0]});
            sclk = 1'b0;
            wt(HP);
        end
        cs_n = 1'b1;
        wt(HP);
        chk(sdo_oe === 1'b0, "R7 oe off", {31'd0, sdo_oe}, 0);
        if (n > 0 && n % 8 == 0) model = seed;
        e = expect_out(model, dir_n);
        chk(drv_on === e, req, {24'd0, drv_on}, {24'd0, e});
    endtask

    initial begin
        wt(4);
        // R6 reset state with direct inputs pulled low
        dir_n = 2'b00;
        wt(1);
        chk(drv_on === 8'h00, "R6 rst forces off", {24'd0, drv_on}, 0);
        chk(sdo_oe === 1'b0, "R7 idle oe", {31'd0, sdo_oe}, 0);
        rst = 1'b0;
        dir_n = 2'b11;
        wt(4);
        chk(drv_on === 8'h00, "R6 latch cleared", {24'd0, drv_on}, 0);

        // R1 R5 exhaustive latch values, R4 all direct combinations
        for (int v = 0; v < 256; v++) begin
            dir_n = 2'b11;
            frame(8, v[7:0], ~v[7:0], "R1 latched byte");
            for (int d = 0; d < 4; d++) begin
                logic [7:0] e;
                dir_n = d[1:0];
                wt(1);
                e = expect_out(model, dir_n);
                chk(drv_on[1:0] === e[1:0], "R4 ch1-2 combine",
                    {30'd0, drv_on[1:0]}, {30'd0, e[1:0]});
                chk(drv_on[7:2] === e[7:2], "R5 ch3-8 follow",
                    {26'd0, drv_on[7:2]}, {26'd0, e[7:2]});
            end
        end
        dir_n = 2'b11;

        // R2 frame length rule, preceded by a known valid write each time
        for (int n = 0; n < 21; n++) begin
            int len;
            len = (n < 18) ? n : ((n == 18) ? 24 : 32);
            frame(8, 8'hA5, 8'h3C, "R2 preset");
            frame(len, 8'h5A ^ n[7:0], 8'hC3, "R2 length rule");
        end

        // R3 long frame
        frame(8, 8'h0F, 8'h81, "R3 preset");
        frame(256, 8'hB2, 8'h7E, "R3 256 clocks");

        // R6 each reset source, direct inputs low
        frame(8, 8'hFF, 8'h00, "R6 preset");
        dir_n = 2'b00;
        uv_rst = 1'b1;
        wt(2);
        chk(drv_on === 8'h00, "R6 undervoltage off", {24'd0, drv_on}, 0);
        uv_rst = 1'b0;
        wt(2);
        model = 8'h00;
        chk(drv_on === 8'h03, "R6 latch clear uv", {24'd0, drv_on}, 3);
        frame(8, 8'hFF, 8'h00, "R6 preset2");
        ext_rst_n = 1'b0;
        wt(2);
        chk(drv_on === 8'h00, "R6 ext reset off", {24'd0, drv_on}, 0);
        ext_rst_n = 1'b1;
        dir_n = 2'b11;
        wt(2);
        model = 8'h00;
        chk(drv_on === 8'h00, "R6 latch clear ext", {24'd0, drv_on}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule